// File: doc/BRIEF.md
# Packed-Word FIFO and Event Unit

This block is the processor-facing half of a serial peripheral interface controller. It sits between a 32-bit register bus and a serial shift engine. Software writes whole 32-bit words into a transmit data register and reads whole words from a receive data register. Each word holds several characters. When characters are 8 bits or shorter, a word carries four of them. When characters are 9 to 16 bits, a word carries two. The unit splits each transmit word into characters and queues them. The shift engine takes characters one at a time. In the other direction, characters arriving from the engine are queued and packed back into words on each read.

Both queues hold 32 characters. An event register shows the live character count of each queue. Next to the counts it shows two level flags that compare those counts against thresholds set in a mode register. It also holds two sticky error flags, one for overflow and one for underflow. A mask register selects which of these events drive the single interrupt line. The last word of a receive transfer may hold fewer characters than a full word. Software waits until the receive count covers the characters it still needs, then reads. The read returns only the characters that are present.

Top module: `pwf_unit`

## Requirements
- R1: After reset:
  - the event register (address 1) reads 0x00000100;
  - the mode register (address 0) reads 0x00000403, which is transmit threshold 4 in bits 13:8 and receive threshold 3 in bits 5:0;
  - the mask register (address 2) reads 0;
  - `irq` and `tx_valid` are low.
- R2: A bus write to the transmit data register (address 3) queues four characters when `char_len_m1` is 7 or less, and two characters when it is 8 to 15. The transmit character count appears in event bits 21:16.
- R3: Queued transmit characters leave on `tx_char`, one for each cycle in which `tx_ready` is high and `tx_valid` is high. They leave in this order: most significant byte slot (or halfword slot) of the written word first. Each character is right-aligned and masked to `char_len_m1`+1 bits. `tx_valid` is low when the transmit queue is empty.
- R4: A bus read of the receive data register (address 4) removes min(characters per word, receive count) characters. The oldest character goes in the most significant slot. Slots with no character read as zero. Characters from `rx_char` are masked to `char_len_m1`+1 bits. The receive count appears in event bits 29:24.
- R5: Event bit 9 (receive not-empty) is 1 exactly when the receive count is greater than the receive threshold.
- R6: Event bit 8 (transmit not-full) is 1 exactly when the free space, 32 minus the transmit count, is greater than the transmit threshold.
- R7: Event bit 1 (overflow) is sticky. It is set in two cases:
  - a transmit write arrives without room for the whole word, and no character of that word is queued;
  - a receive character arrives while the receive queue is full, and the character is dropped.
- R8: Event bit 0 (underflow) is sticky. It is set by a receive data read while the receive queue is empty. That read returns 0.
- R9: Writing the event register clears each sticky bit (bits 1 and 0) written as 1. Character counts and level flags are not affected.
- R10: `irq` is the OR, over event bits 9, 8, 1 and 0, of each event bit ANDed with the mask bit at the same position. The mask register keeps and reads back only those four bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe; a read of address 4 removes characters |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read strobe |
| char_len_m1 | input | 4 | Character length minus one (3 to 15) |
| tx_valid | output | 1 | Transmit queue holds a character |
| tx_ready | input | 1 | Shift engine takes the character on `tx_char` |
| tx_char | output | 16 | Oldest transmit character, right-aligned |
| rx_valid | input | 1 | Shift engine delivers a received character |
| rx_char | input | 16 | Received character, right-aligned |
| irq | output | 1 | Masked event interrupt |

## Verification
Register reads are combinational, so `bus_rdata` is valid in the same cycle as the read strobe, before the edge that applies any removal.

A write, a delivered character or a `tx_ready` pop changes counts, flags and `irq` at the next rising edge. Those changes are visible for the whole following cycle.

The bench drives every access at a falling edge and samples outputs 1 ns later. This means each read sees the effect of all accesses made in earlier cycles, and none of its own.

The sweeps cover every character length from 4 to 16 bits for both directions. Expected characters and packed words are computed from shifts and masks. Threshold flags are checked on both sides of each comparison. Overflow and underflow are checked at exact-fit and one-beyond-fit fill levels.

// File: rtl/pwf_pkg.sv
package pwf_pkg;
  localparam int WORD_W   = 32;
  localparam int SLOT_W   = 8;
  localparam int LANES    = WORD_W / SLOT_W;
  localparam int CHAR_W   = 2 * SLOT_W;
  localparam int ADDR_W   = 3;
  localparam int THR_W    = 6;
  localparam int CNTF_W   = 6;

  localparam logic [ADDR_W-1:0] A_MODE  = 3'd0;
  localparam logic [ADDR_W-1:0] A_EVENT = 3'd1;
  localparam logic [ADDR_W-1:0] A_MASK  = 3'd2;
  localparam logic [ADDR_W-1:0] A_TXD   = 3'd3;
  localparam logic [ADDR_W-1:0] A_RXD   = 3'd4;

  localparam logic [THR_W-1:0] TX_THR_RST = 6'd4;
  localparam logic [THR_W-1:0] RX_THR_RST = 6'd3;

  // event / mask bit positions
  localparam int EV_RXNE = 9;
  localparam int EV_TXNF = 8;
  localparam int EV_OVF  = 1;
  localparam int EV_UNF  = 0;
  localparam int EV_RXC  = 24;
  localparam int EV_TXC  = 16;

  typedef logic [CHAR_W-1:0] char_t;

  // mask of len_m1+1 low ones
  function automatic char_t width_mask(input logic [3:0] len_m1);
    logic [CHAR_W:0] one;
    one = (CHAR_W+1)'(1) << (32'(len_m1) + 1);
    return char_t'(one - (CHAR_W+1)'(1));
  endfunction
endpackage

// File: rtl/pwf_fifo.sv
module pwf_fifo
  import pwf_pkg::*;
#(
  parameter int DEPTH       = 32,   // power of two
  parameter int PUSH_LANES  = 4,
  parameter int PEEK_LANES  = 1,
  localparam int PTR_W      = $clog2(DEPTH),
  localparam int CNT_W      = $clog2(DEPTH + 1),
  localparam int PUSH_W     = $clog2(PUSH_LANES + 1),
  localparam int POP_W      = $clog2(PEEK_LANES + 1)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [PUSH_W-1:0]                push_n,
  input  logic [PUSH_LANES-1:0][CHAR_W-1:0] push_data,
  input  logic [POP_W-1:0]                 pop_n,
  output logic [PEEK_LANES-1:0][CHAR_W-1:0] peek,
  output logic [CNT_W-1:0]                 count
);
  logic [CHAR_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0]  rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              ptr_en;

  always_comb begin
    ptr_en   = (push_n != '0) || (pop_n != '0);
    wr_ptr_d = wr_ptr_q + PTR_W'(push_n);
    rd_ptr_d = rd_ptr_q + PTR_W'(pop_n);
    cnt_d    = cnt_q + CNT_W'(push_n) - CNT_W'(pop_n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (ptr_en) begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < PUSH_LANES; k++) begin
      if (k < int'(push_n)) mem_q[wr_ptr_q + PTR_W'(k)] <= push_data[k];
    end
  end

  always_comb begin
    for (int k = 0; k < PEEK_LANES; k++) peek[k] = mem_q[rd_ptr_q + PTR_W'(k)];
  end

  assign count = cnt_q;
endmodule

// File: rtl/pwf_events.sv
module pwf_events
  import pwf_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  tx_cnt,
  input  logic [CNT_W-1:0]  rx_cnt,
  input  logic [THR_W-1:0]  tx_thr,
  input  logic [THR_W-1:0]  rx_thr,
  input  logic              set_ovf,
  input  logic              set_unf,
  input  logic              clr_we,
  input  logic [1:0]        clr_bits,   // {ovf, unf}
  input  logic              mask_we,
  input  logic [3:0]        mask_bits,  // {rxne, txnf, ovf, unf}
  output logic [WORD_W-1:0] evt_word,
  output logic [WORD_W-1:0] mask_word,
  output logic [1:0]        sticky,
  output logic [3:0]        mask,
  output logic              irq
);
  logic [1:0] sticky_q, sticky_d;
  logic [3:0] mask_q, mask_d;
  logic       rx_ne, tx_nf;
  logic [3:0] flags;

  always_comb begin
    rx_ne    = int'(rx_cnt) > int'(rx_thr);
    tx_nf    = (DEPTH - int'(tx_cnt)) > int'(tx_thr);
    sticky_d = (sticky_q & ~(clr_we ? clr_bits : 2'b00)) | {set_ovf, set_unf};
    mask_d   = mask_we ? mask_bits : mask_q;
    flags    = {rx_ne, tx_nf, sticky_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky_q <= '0;
      mask_q   <= '0;
    end else begin
      sticky_q <= sticky_d;
      if (mask_we) mask_q <= mask_d;
    end
  end

  always_comb begin
    evt_word                       = '0;
    evt_word[EV_RXC +: CNTF_W]     = CNTF_W'(rx_cnt);
    evt_word[EV_TXC +: CNTF_W]     = CNTF_W'(tx_cnt);
    evt_word[EV_RXNE]              = flags[3];
    evt_word[EV_TXNF]              = flags[2];
    evt_word[EV_OVF]               = flags[1];
    evt_word[EV_UNF]               = flags[0];
    mask_word                      = '0;
    mask_word[EV_RXNE]             = mask_q[3];
    mask_word[EV_TXNF]             = mask_q[2];
    mask_word[EV_OVF]              = mask_q[1];
    mask_word[EV_UNF]              = mask_q[0];
  end

  assign irq    = |(flags & mask_q);
  assign sticky = sticky_q;
  assign mask   = mask_q;
endmodule

// File: rtl/pwf_unit.sv
module pwf_unit
  import pwf_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_en,
  input  logic              bus_rd_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic [3:0]        char_len_m1,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [CHAR_W-1:0] tx_char,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_char,
  output logic              irq
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int LN_W  = $clog2(LANES + 1);
  localparam int HALF  = WORD_W / CHAR_W;

  logic [THR_W-1:0] tx_thr_q, tx_thr_d, rx_thr_q, rx_thr_d;
  logic             mode_we;
  logic             wide;
  logic [LN_W-1:0]  pack_n;
  char_t            cmask;

  logic [CNT_W-1:0]             tx_cnt, rx_cnt;
  logic                         tx_wr, tx_room;
  logic [LN_W-1:0]              tx_push_n;
  logic [LANES-1:0][CHAR_W-1:0] tx_lanes;
  logic [0:0][CHAR_W-1:0]       tx_peek;
  logic                         tx_pop_n;

  logic                         rx_push_n, rx_full, rx_rd;
  logic [0:0][CHAR_W-1:0]       rx_lane;
  logic [LN_W-1:0]              rx_take, rx_pop_n;
  logic [LANES-1:0][CHAR_W-1:0] rx_peek;
  logic [WORD_W-1:0]            rx_word;

  logic              set_ovf, set_unf, evt_we, mask_we;
  logic [WORD_W-1:0] evt_word, mask_word;
  logic [1:0]        sticky;
  logic [3:0]        mask;

  // ---- configuration ----
  always_comb begin
    wide    = char_len_m1 >= 4'd8;
    pack_n  = wide ? LN_W'(HALF) : LN_W'(LANES);
    cmask   = width_mask(char_len_m1);
    mode_we = bus_wr_en && (bus_addr == A_MODE);
    tx_thr_d = mode_we ? bus_wdata[8 +: THR_W] : tx_thr_q;
    rx_thr_d = mode_we ? bus_wdata[0 +: THR_W] : rx_thr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_thr_q <= TX_THR_RST;
      rx_thr_q <= RX_THR_RST;
    end else if (mode_we) begin
      tx_thr_q <= tx_thr_d;
      rx_thr_q <= rx_thr_d;
    end
  end

  // ---- transmit side: unpack one bus word into characters ----
  always_comb begin
    tx_wr     = bus_wr_en && (bus_addr == A_TXD);
    tx_room   = (DEPTH - int'(tx_cnt)) >= int'(pack_n);
    tx_push_n = (tx_wr && tx_room) ? pack_n : '0;
    tx_lanes  = '0;
    if (wide) begin
      for (int k = 0; k < HALF; k++)
        tx_lanes[k] = bus_wdata[(HALF-1-k)*CHAR_W +: CHAR_W] & cmask;
    end else begin
      for (int k = 0; k < LANES; k++)
        tx_lanes[k] = {{(CHAR_W-SLOT_W){1'b0}}, bus_wdata[(LANES-1-k)*SLOT_W +: SLOT_W]} & cmask;
    end
    tx_pop_n = tx_ready && (tx_cnt != '0);
  end

  pwf_fifo #(.DEPTH(DEPTH), .PUSH_LANES(LANES), .PEEK_LANES(1)) u_tx_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_n   (tx_push_n),
    .push_data(tx_lanes),
    .pop_n    (tx_pop_n),
    .peek     (tx_peek),
    .count    (tx_cnt)
  );

  assign tx_valid = tx_cnt != '0;
  assign tx_char  = tx_peek[0];

  // ---- receive side: pack characters into one bus word ----
  always_comb begin
    rx_full    = int'(rx_cnt) == DEPTH;
    rx_push_n  = rx_valid && !rx_full;
    rx_lane[0] = rx_char & cmask;
    rx_rd      = bus_rd_en && (bus_addr == A_RXD);
    rx_take    = (int'(rx_cnt) < int'(pack_n)) ? LN_W'(rx_cnt) : pack_n;
    rx_pop_n   = rx_rd ? rx_take : '0;
    rx_word    = '0;
    if (wide) begin
      for (int k = 0; k < HALF; k++)
        if (k < int'(rx_take)) rx_word[(HALF-1-k)*CHAR_W +: CHAR_W] = rx_peek[k];
    end else begin
      for (int k = 0; k < LANES; k++)
        if (k < int'(rx_take)) rx_word[(LANES-1-k)*SLOT_W +: SLOT_W] = rx_peek[k][SLOT_W-1:0];
    end
  end

  pwf_fifo #(.DEPTH(DEPTH), .PUSH_LANES(1), .PEEK_LANES(LANES)) u_rx_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_n   (rx_push_n),
    .push_data(rx_lane),
    .pop_n    (rx_pop_n),
    .peek     (rx_peek),
    .count    (rx_cnt)
  );

  // ---- events ----
  always_comb begin
    set_ovf = (tx_wr && !tx_room) || (rx_valid && rx_full);
    set_unf = rx_rd && (rx_cnt == '0);
    evt_we  = bus_wr_en && (bus_addr == A_EVENT);
    mask_we = bus_wr_en && (bus_addr == A_MASK);
  end

  pwf_events #(.DEPTH(DEPTH)) u_events (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_cnt   (tx_cnt),
    .rx_cnt   (rx_cnt),
    .tx_thr   (tx_thr_q),
    .rx_thr   (rx_thr_q),
    .set_ovf  (set_ovf),
    .set_unf  (set_unf),
    .clr_we   (evt_we),
    .clr_bits ({bus_wdata[EV_OVF], bus_wdata[EV_UNF]}),
    .mask_we  (mask_we),
    .mask_bits({bus_wdata[EV_RXNE], bus_wdata[EV_TXNF], bus_wdata[EV_OVF], bus_wdata[EV_UNF]}),
    .evt_word (evt_word),
    .mask_word(mask_word),
    .sticky   (sticky),
    .mask     (mask),
    .irq      (irq)
  );

  // ---- register read mux ----
  always_comb begin
    unique case (bus_addr)
      A_MODE:  bus_rdata = {{(WORD_W-8-THR_W){1'b0}}, tx_thr_q, 2'b00, rx_thr_q};
      A_EVENT: bus_rdata = evt_word;
      A_MASK:  bus_rdata = mask_word;
      A_RXD:   bus_rdata = rx_word;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pwf_unit_chk.sv
module pwf_unit_chk
  import pwf_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int CNT_W = 6,
  parameter int LN_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr_en,
  input logic              bus_rd_en,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [1:0]        w1c_bits,
  input logic              tx_ready,
  input logic              rx_valid,
  input logic              irq,
  input logic [CNT_W-1:0]  tx_cnt,
  input logic [CNT_W-1:0]  rx_cnt,
  input logic [LN_W-1:0]   pack_n,
  input logic [1:0]        sticky,
  input logic [3:0]        mask
);
  logic tx_wr, rx_rd, evt_wr;
  assign tx_wr  = bus_wr_en && (bus_addr == A_TXD);
  assign rx_rd  = bus_rd_en && (bus_addr == A_RXD);
  assign evt_wr = bus_wr_en && (bus_addr == A_EVENT);

  AST_TX_WORD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr && !tx_ready && ((DEPTH - int'(tx_cnt)) >= int'(pack_n))
    |=> int'(tx_cnt) == int'($past(tx_cnt)) + int'($past(pack_n))); // R2

  AST_TX_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_wr && tx_ready && (tx_cnt != '0)
    |=> int'(tx_cnt) == int'($past(tx_cnt)) - 1); // R3

  AST_RX_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rd && !rx_valid && (int'(rx_cnt) >= int'(pack_n))
    |=> int'(rx_cnt) == int'($past(rx_cnt)) - int'($past(pack_n))); // R4

  AST_NO_ROOM_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr && !tx_ready && ((DEPTH - int'(tx_cnt)) < int'(pack_n))
    |=> sticky[1] && $stable(tx_cnt)); // R7

  AST_RX_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && (int'(rx_cnt) == DEPTH) && !rx_rd
    |=> (int'(rx_cnt) == DEPTH) && sticky[1]); // R7

  AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    sticky[1] && !(evt_wr && w1c_bits[1]) |=> sticky[1]); // R7

  AST_UNF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rd && (rx_cnt == '0) |=> sticky[0]); // R8

  AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    evt_wr && w1c_bits[0] |=> !sticky[0]); // R9

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == 4'b0000) |-> !irq); // R10
endmodule

bind pwf_unit pwf_unit_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W), .LN_W(LN_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_wr_en(bus_wr_en),
  .bus_rd_en(bus_rd_en),
  .bus_addr (bus_addr),
  .w1c_bits (bus_wdata[1:0]),
  .tx_ready (tx_ready),
  .rx_valid (rx_valid),
  .irq      (irq),
  .tx_cnt   (tx_cnt),
  .rx_cnt   (rx_cnt),
  .pack_n   (pack_n),
  .sticky   (sticky),
  .mask     (mask)
);

// File: tb/pwf_unit_bench.sv
module pwf_unit_bench;
  import pwf_pkg::*;

  logic              clk;
  logic              rst_n;
  logic              bus_wr_en, bus_rd_en;
  logic [ADDR_W-1:0] bus_addr;
  logic [31:0]       bus_wdata, bus_rdata;
  logic [3:0]        char_len_m1;
  logic              tx_valid, tx_ready, rx_valid, irq;
  logic [15:0]       tx_char, rx_char;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  pwf_unit u_pwf_unit (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .char_len_m1(char_len_m1), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_char(tx_char), .rx_valid(rx_valid), .rx_char(rx_char), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_rd_en = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd_en = 1'b0;
  endtask

  task automatic pop(output logic ok, output logic [15:0] c);
    tx_ready = 1'b1;
    #1 begin ok = tx_valid; c = tx_char; end
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  task automatic push(input logic [15:0] c);
    rx_valid = 1'b1; rx_char = c;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  function automatic logic [15:0] cmask(input int lm);
    return 16'((32'd1 << (lm + 1)) - 1);
  endfunction

  function automatic logic [15:0] exp_tx(input logic [31:0] w, input int lm, input int k);
    if (lm >= 8) return 16'(w >> (16 - 16*k)) & cmask(lm);
    return 16'((w >> (24 - 8*k)) & 32'hFF) & cmask(lm);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, w, e;
    logic        ok;
    logic [15:0] c, r;
    int          pk;
    rst_n = 1'b0; bus_wr_en = 1'b0; bus_rd_en = 1'b0; bus_addr = '0; bus_wdata = '0;
    char_len_m1 = 4'd7; tx_ready = 1'b0; rx_valid = 1'b0; rx_char = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_EVENT, v); check("R1 event", v, 32'h0000_0100);
    rd(A_MODE, v);  check("R1 mode", v, 32'h0000_0403);
    rd(A_MASK, v);  check("R1 mask", v, 32'h0);
    check("R1 irq", irq, 1'b0);
    check("R1 tx_valid", tx_valid, 1'b0);

    // R2 / R3 transmit sweep over every character length
    for (int lm = 3; lm <= 15; lm++) begin
      char_len_m1 = 4'(lm);
      pk = (lm >= 8) ? 2 : 4;
      for (int p = 0; p < 3; p++) begin
        w = 32'h9E37_79B9 * (lm*3 + p + 1);
        wr(A_TXD, w);
        rd(A_EVENT, v); check("R2 tx count", 32'(v[21:16]), 32'(pk));
        for (int k = 0; k < pk; k++) begin
          pop(ok, c);
          check("R3 tx_valid", ok, 1'b1);
          check("R3 tx_char", c, exp_tx(w, lm, k));
        end
        #1 check("R3 drained", tx_valid, 1'b0);
      end
    end

    // R4 receive sweep over every character length
    for (int lm = 3; lm <= 15; lm++) begin
      char_len_m1 = 4'(lm);
      pk = (lm >= 8) ? 2 : 4;
      for (int p = 0; p < 2; p++) begin
        e = '0;
        for (int k = 0; k < pk; k++) begin
          r = 16'hA000 | 16'(lm*37 + k*91 + p*13 + 5);
          c = r & cmask(lm);
          push(r);
          e = e | ((lm >= 8) ? (32'(c) << (16 - 16*k)) : (32'(c) << (24 - 8*k)));
        end
        rd(A_EVENT, v); check("R4 rx count", 32'(v[29:24]), 32'(pk));
        rd(A_RXD, v);   check("R4 rx word", v, e);
        rd(A_EVENT, v); check("R4 rx count after", 32'(v[29:24]), 32'd0);
      end
    end

    // R4 partial final words
    char_len_m1 = 4'd7;
    push(16'h11); push(16'h22); push(16'h33);
    rd(A_RXD, v);   check("R4 partial bytes", v, 32'h1122_3300);
    rd(A_EVENT, v); check("R4 partial no unf", {v[29:24], v[0]}, 7'd0);
    char_len_m1 = 4'd15;
    push(16'hBEEF);
    rd(A_RXD, v);   check("R4 partial half", v, 32'hBEEF_0000);

    // R5 receive threshold
    char_len_m1 = 4'd7;
    push(16'h1); push(16'h2); push(16'h3);
    rd(A_EVENT, v); check("R5 at threshold", v[9], 1'b0);
    push(16'h4);
    rd(A_EVENT, v); check("R5 above threshold", v[9], 1'b1);
    rd(A_RXD, v);   check("R5 drain word", v, 32'h0102_0304);
    wr(A_MODE, 32'h0000_0400);
    rd(A_MODE, v);  check("R5 mode readback", v, 32'h0000_0400);
    rd(A_EVENT, v); check("R5 empty thr0", v[9], 1'b0);
    push(16'h5);
    rd(A_EVENT, v); check("R5 one char thr0", v[9], 1'b1);
    rd(A_RXD, v);
    wr(A_MODE, 32'h0000_0403);

    // R6 transmit threshold
    wr(A_MODE, 32'h0000_1C03);
    rd(A_EVENT, v); check("R6 free 32 > 28", v[8], 1'b1);
    wr(A_TXD, 32'hA1A2_A3A4);
    rd(A_EVENT, v); check("R6 free 28", v[8], 1'b0);
    pop(ok, c);
    rd(A_EVENT, v); check("R6 free 29", v[8], 1'b1);
    for (int k = 0; k < 3; k++) pop(ok, c);
    wr(A_MODE, 32'h0000_0403);

    // R7 transmit overflow, narrow characters
    for (int i = 0; i < 8; i++) wr(A_TXD, 32'h0102_0304 + 32'h0404_0404 * i);
    rd(A_EVENT, v); check("R7 tx full count", {v[21:16], v[1]}, {6'd32, 1'b0});
    wr(A_TXD, 32'hDEAD_BEEF);
    rd(A_EVENT, v); check("R7 tx ovf", {v[21:16], v[1]}, {6'd32, 1'b1});
    for (int k = 0; k < 32; k++) begin
      pop(ok, c);
      check("R7 tx content kept", {ok, c}, {1'b1, 16'(k + 1)});
    end
    #1 check("R7 tx empty", tx_valid, 1'b0);
    wr(A_EVENT, 32'h0000_0002);
    rd(A_EVENT, v); check("R9 ovf cleared", v[1], 1'b0);

    // R7 transmit exact fit and overflow, wide characters
    char_len_m1 = 4'd15;
    for (int i = 0; i < 16; i++) wr(A_TXD, 32'h1000_2000 + i);
    rd(A_EVENT, v); check("R7 wide exact fit", {v[21:16], v[1]}, {6'd32, 1'b0});
    wr(A_TXD, 32'h5555_6666);
    rd(A_EVENT, v); check("R7 wide ovf", {v[21:16], v[1]}, {6'd32, 1'b1});
    for (int k = 0; k < 32; k++) pop(ok, c);
    check("R7 wide last char", c, 16'h200F);
    wr(A_EVENT, 32'hFFFF_FFFF);

    // R7 receive overflow
    char_len_m1 = 4'd7;
    for (int i = 0; i < 33; i++) push(16'(i));
    rd(A_EVENT, v); check("R7 rx ovf", {v[29:24], v[1]}, {6'd32, 1'b1});
    rd(A_RXD, v);   check("R7 rx first word", v, 32'h0001_0203);
    for (int i = 1; i < 7; i++) rd(A_RXD, v);
    rd(A_RXD, v);   check("R7 rx last word", v, 32'h1C1D_1E1F);

    // R8 underflow
    rd(A_RXD, v);   check("R8 empty read data", v, 32'h0);
    rd(A_EVENT, v); check("R8 unf set", {v[29:24], v[1], v[0]}, {6'd0, 1'b1, 1'b1});

    // R9 selective and full clear
    for (int i = 0; i < 32; i++) push(16'(i));
    wr(A_EVENT, 32'h0000_0002);
    rd(A_EVENT, v); check("R9 clear ovf only", {v[1], v[0]}, 2'b01);
    wr(A_EVENT, 32'hFFFF_FFFF);
    rd(A_EVENT, v); check("R9 clear all", v, 32'h2000_0300);
    for (int i = 0; i < 8; i++) rd(A_RXD, v);

    // R10 interrupt gating
    #1 check("R10 mask zero", irq, 1'b0);
    wr(A_MASK, 32'h0000_0100);
    #1 check("R10 txnf enabled", irq, 1'b1);
    wr(A_MASK, 32'h0000_0200);
    #1 check("R10 rxne idle", irq, 1'b0);
    for (int i = 0; i < 4; i++) push(16'(i));
    #1 check("R10 rxne raised", irq, 1'b1);
    rd(A_RXD, v);
    #1 check("R10 rxne dropped", irq, 1'b0);
    wr(A_MASK, 32'h0000_0001);
    rd(A_RXD, v);
    #1 check("R10 unf raised", irq, 1'b1);
    wr(A_EVENT, 32'h0000_0001);
    #1 check("R10 unf cleared", irq, 1'b0);
    wr(A_MASK, 32'hFFFF_FFFF);
    rd(A_MASK, v); check("R10 mask bits", v, 32'h0000_0303);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule